// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady periodic event. A fixed divide-by-16 prescaler drives a 20-bit position counter. The counter climbs from zero to a programmed limit, then wraps. Each wrap sets a sticky status flag and adds one to a 12-bit count of elapsed periods. That count saturates, so missed service is never hidden. A level interrupt is raised while the flag is set and the interrupt is enabled.

Software sees the counter state in two views. The acknowledge view returns the elapsed-period count together with the current position, and reading it clears the flag and the count. The snapshot view returns the same word with no side effect. Clearing the run bit does not stop the timer at once: the period in progress finishes, and the counter then parks at zero.

Top module: `interval_timer`

## Requirements
- R1: While the timer runs, the position counter advances exactly once every 16 clock cycles. The prescaler starts from zero whenever the timer is idle.
- R2: The control word at offset 0x0 holds the limit in bits 19:0, the run bit in bit 24 and the interrupt-enable bit in bit 25. It reads back with all other bits zero.
- R3: One period lasts limit+1 advances. The position goes 0, 1, … limit and then back to 0. If the limit is lowered below the current position, the next advance wraps to 0.
- R4: Offset 0x4 reads the sticky period flag in bit 0 and zero elsewhere. Every wrap sets the flag.
- R5: Offset 0x8 reads the elapsed-period count in bits 31:20 and the position in bits 19:0. A read there clears the flag and the count.
- R6: Offset 0xC reads the same word as offset 0x8 and changes nothing.
- R7: After the run bit is cleared, the counter keeps advancing until the position next returns to 0. It then holds at 0.
- R8: irqOut is high exactly while the flag and the interrupt-enable bit are both set. Clearing interrupt-enable does not stop the counter.
- R9: The elapsed-period count saturates at 4095 and does not wrap.
- R10: If a wrap and an acknowledging read fall in the same cycle, the count becomes 1 and the flag stays set.
- R11: Writes to offsets 0x4, 0x8 and 0xC change nothing. Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return 0.
- R12: After reset, all registers, the prescaler and irqOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe (triggers the acknowledge side effect) |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench drives an acknowledging read on every cycle while the limit is zero. This places reads exactly on wrap cycles. A design that let the clear win would lose a period, and one that let the increment win would double-count. It lowers the limit beneath the live position; a design that compares for equality would run the counter on toward its 20-bit rollover. It clears the run bit mid-period and checks that the counter finishes the period and then parks at zero, rather than freezing mid-count or running on. It lets 4100 periods pass without service; a wrapping count would read back a small number instead of 4095.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam logic [3:0] ADDR_MODE = 4'h0;
  localparam logic [3:0] ADDR_STAT = 4'h4;
  localparam logic [3:0] ADDR_ACKV = 4'h8;
  localparam logic [3:0] ADDR_IMGV = 4'hC;
  localparam int RUN_BIT = 24;
  localparam int IEN_BIT = 25;

  typedef struct packed {
    logic tick;  // prescaled advance this cycle
    logic ack;   // acknowledging read this cycle
  } itmr_strb_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int PRESC  = 16,
  parameter int VAL_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  input  logic              valNonZero,
  output logic [VAL_W-1:0]  limit,
  output logic              runEn,
  output logic              irqEn,
  output itmr_strb_t        strb
);
  localparam int PW = $clog2(PRESC);
  localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

  logic [PW-1:0] presc;
  logic running;
  logic unusedWdata;

  assign unusedWdata = ^{busWdata[DATA_W-1:IEN_BIT+1], busWdata[RUN_BIT-1:VAL_W]};
  assign running = runEn | valNonZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
      limit <= '0;
      runEn <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (running) presc <= (presc == PLAST) ? '0 : presc + 1'b1;
      else         presc <= '0;
      if (busWe && busAddr == ADDR_MODE) begin
        limit <= busWdata[VAL_W-1:0];
        runEn <= busWdata[RUN_BIT];
        irqEn <= busWdata[IEN_BIT];
      end
    end
  end

  always_comb begin
    strb.tick = running && (presc == PLAST);
    strb.ack  = busRe && (busAddr == ADDR_ACKV);
  end
endmodule

// File: rtl/itmr_dp.sv
module itmr_dp
  import itmr_pkg::*;
#(
  parameter int VAL_W = 20,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  itmr_strb_t       strb,
  input  logic [VAL_W-1:0] limit,
  output logic [VAL_W-1:0] curVal,
  output logic [CNT_W-1:0] ovfCnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;
  assign wrap = strb.tick && (curVal >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curVal <= '0;
      ovfCnt <= '0;
      flag   <= 1'b0;
    end else begin
      if (strb.tick) curVal <= wrap ? '0 : curVal + 1'b1;
      if (wrap) begin
        if (strb.ack)                ovfCnt <= CNT_W'(1);
        else if (ovfCnt != CNT_MAX)  ovfCnt <= ovfCnt + 1'b1;
        flag <= 1'b1;
      end else if (strb.ack) begin
        ovfCnt <= '0;
        flag   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int PRESC  = 16,
  parameter int VAL_W  = 20,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  itmr_strb_t       strb;
  logic [VAL_W-1:0] limit;
  logic [VAL_W-1:0] curVal;
  logic [CNT_W-1:0] ovfCnt;
  logic             runEn;
  logic             irqEn;
  logic             flag;

  itmr_ctrl #(.PRESC(PRESC), .VAL_W(VAL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .valNonZero(curVal != '0),
    .limit(limit), .runEn(runEn), .irqEn(irqEn), .strb(strb)
  );

  itmr_dp #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .limit(limit),
    .curVal(curVal), .ovfCnt(ovfCnt), .flag(flag)
  );

  assign irqOut = flag & irqEn;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_MODE: begin
        busRdata[VAL_W-1:0] = limit;
        busRdata[RUN_BIT]   = runEn;
        busRdata[IEN_BIT]   = irqEn;
      end
      ADDR_STAT: busRdata[0] = flag;
      ADDR_ACKV, ADDR_IMGV: begin
        busRdata[VAL_W-1:0]     = curVal;
        busRdata[VAL_W +: CNT_W] = ovfCnt;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int VAL_W = 20,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       busAddr,
  input logic             busRe,
  input logic             irqOut,
  input logic             tick,
  input logic             runEn,
  input logic [VAL_W-1:0] limit,
  input logic [VAL_W-1:0] curVal,
  input logic [CNT_W-1:0] ovfCnt,
  input logic             flag
);
  // R1
  stable_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(curVal));
  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && curVal >= limit) |=> flag);
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 4'h8 && !tick) |=> (!flag && ovfCnt == '0));
  // R7
  parked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && curVal == '0) |=> curVal == '0);
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flag);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCnt == '1 && !(busRe && busAddr == 4'h8)) |=> ovfCnt == '1);
endmodule

bind interval_timer itmr_chk #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRe(busRe), .irqOut(irqOut),
  .tick(strb.tick), .runEn(runEn), .limit(limit), .curVal(curVal),
  .ovfCnt(ovfCnt), .flag(flag)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;

  always #10 clk = ~clk;  // 50 MHz

  interval_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .irqOut(irqOut)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  // reference model state
  int mLim = 0, mRun = 0, mIen = 0, mPresc = 0, mVal = 0, mCnt = 0, mFlag = 0;
  logic [31:0] lastRd;

  function automatic logic [31:0] expRd(logic [3:0] a);
    case (a)
      4'h0: return {6'd0, mIen[0], mRun[0], 4'd0, mLim[19:0]};
      4'h4: return {31'd0, mFlag[0]};
      4'h8, 4'hC: return {mCnt[11:0], mVal[19:0]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(logic [3:0] a);
    case (a)
      4'h0: return "R2";
      4'h4: return "R4";
      4'h8: return "R5";
      4'hC: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic [3:0] a, logic we, logic [31:0] wd, logic re);
    bit tick, wrap, ack;
    tick = 0;
    if (mRun != 0 || mVal != 0) begin
      if (mPresc == 15) begin mPresc = 0; tick = 1; end
      else mPresc++;
    end else mPresc = 0;
    wrap = tick && (mVal >= mLim);
    ack = re && a == 4'h8;
    if (tick) mVal = wrap ? 0 : mVal + 1;
    if (wrap) begin
      mCnt = ack ? 1 : (mCnt < 4095 ? mCnt + 1 : 4095);
      mFlag = 1;
    end else if (ack) begin
      mCnt = 0; mFlag = 0;
    end
    if (we && a == 4'h0) begin
      mLim = int'(wd[19:0]); mRun = int'(wd[24]); mIen = int'(wd[25]);
    end
  endtask

  task automatic step(string tag, logic [3:0] a, logic we, logic [31:0] wd, logic re);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = wd; busRe = re;
    #2;
    lastRd = busRdata;
    check((tag == "") ? tagFor(a) : tag, busRdata, expRd(a));
    check("R8", {31'd0, irqOut}, {31'd0, mFlag[0] & mIen[0]});
    @(posedge clk);
    modelStep(a, we, wd, re);
  endtask

  task automatic idle(string tag, logic [3:0] a, int n);
    for (int i = 0; i < n; i++) step(tag, a, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R12: everything zero after reset
    step("R12", 4'h0, 0, 0, 0);
    step("R12", 4'h4, 0, 0, 0);
    step("R12", 4'hC, 0, 0, 0);
    step("R12", 4'h8, 0, 0, 1);
    // R1 R3: limit 3, run, interrupts on
    step("R2", 4'h0, 1, 32'h0300_0003, 0);
    step("R2", 4'h0, 0, 0, 0);
    idle("R3", 4'hC, 200);
    idle("R4", 4'h4, 40);
    for (int i = 0; i < 200; i++) step("", 4'h8, 0, 0, (i % 7) == 0);
    // R10: acknowledge on every cycle with limit 0, so reads land on wraps
    step("", 4'h0, 1, 32'h0300_0000, 0);
    for (int i = 0; i < 64; i++) step("R10", 4'h8, 0, 0, 1);
    // R8: interrupt disabled, counter must keep running
    step("", 4'h0, 1, 32'h0100_0002, 0);
    idle("R8", 4'hC, 100);
    step("R8", 4'h4, 0, 0, 0);
    check("R8", {31'd0, irqOut}, 32'd0);
    // R11: writes elsewhere ignored, undefined offsets read zero
    step("R11", 4'h4, 1, 32'hFFFF_FFFF, 0);
    step("R11", 4'h8, 1, 32'hFFFF_FFFF, 0);
    step("R11", 4'hC, 1, 32'hFFFF_FFFF, 0);
    step("R11", 4'h0, 0, 0, 0);
    check("R11", lastRd, 32'h0100_0002);
    step("R11", 4'h2, 0, 0, 0);
    step("R11", 4'h7, 0, 0, 0);
    step("R11", 4'hF, 0, 0, 0);
    // R3: lower the limit below the live position
    step("", 4'h0, 1, 32'h0300_0032, 0);
    idle("R3", 4'hC, 600);
    step("", 4'h0, 1, 32'h0300_0005, 0);
    idle("R3", 4'hC, 200);
    // R7: clear run mid-period, period finishes then parks
    step("", 4'h0, 1, 32'h0100_00C8, 0);
    idle("R7", 4'hC, 100);
    step("", 4'h0, 1, 32'h0000_00C8, 0);
    idle("R7", 4'hC, 3400);
    check("R7", {12'd0, lastRd[19:0]}, 32'd0);
    // R9: saturation of the elapsed-period count
    step("R5", 4'h8, 0, 0, 1);
    step("", 4'h0, 1, 32'h0100_0000, 0);
    idle("R9", 4'hC, 4100 * 16);
    check("R9", {20'd0, lastRd[31:20]}, 32'd4095);
    step("R9", 4'h8, 0, 0, 1);
    step("R5", 4'hC, 0, 0, 0);
    done = 1;
    summary();
  end
endmodule